// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block links a narrow data port A (one lane wide, 12 bits by default) to a wide data port B. Port B is two lanes: the low lane (bits `LANE_W-1:0`, lane 0) and the high lane (bits `2*LANE_W-1:LANE_W`, lane 1). Going from A to B, each lane has its own capture register. Each register has its own active-low load enable. A producer can steer two A words, one after the other, into the two lanes, and then read them as a single wide word on B.

Going from B to A, one return register picks one lane of B on every clock edge and drives A from that register. Every control input is registered before it acts: the lane select, both load enables and all three output enables. Each port gives its data and a drive flag in place of tri-state pins. A drive flag is high when its registered active-low output enable is low. A synchronous active-low reset puts every drive flag in the not-driving state and clears all data registers.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge `a_drive`, both bits of `b_drive`, `a_out` and `b_out` are all zero.
- R2: If `b_load_n[k]` was low at rising edge N, lane k of `b_out` holds the `a_in` value sampled at edge N+1 (k=0 is bits LANE_W-1:0, k=1 is bits 2*LANE_W-1:LANE_W).
- R3: If `b_load_n[k]` was high at rising edge N, lane k of `b_out` keeps its value across edge N+1, whatever `a_in` is.
- R4: Load enables applied as lane 0 in one cycle and lane 1 in the next, with word W1 and then word W2 on `a_in` one cycle behind each enable, give `b_out = {W2, W1}`.
- R5: If both load enables were low at edge N, both lanes take the same `a_in` value at edge N+1.
- R6: The return register loads at every rising edge. At edge N+1 it takes lane 0 of `b_in` if `pick_low` was 1 at edge N, and lane 1 if `pick_low` was 0. `a_out` shows this register.
- R7: `a_out` and `b_out` change only at rising edges. Changing `a_in` or `b_in` between edges has no effect on them.
- R8: After each rising edge, `a_drive` equals the inverse of `a_oe_n` and `b_drive[k]` equals the inverse of `b_oe_n[k]`, all sampled at that edge. The three flags are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | LANE_W | Data arriving on the narrow port |
| a_oe_n | input | 1 | Active-low output enable for the narrow port (registered) |
| a_out | output | LANE_W | Return register contents driven to the narrow port |
| a_drive | output | 1 | Narrow port drive flag |
| b_in | input | 2*LANE_W | Data arriving on the wide port |
| b_load_n | input | 2 | Active-low load enable per wide lane (registered) |
| b_oe_n | input | 2 | Active-low output enable per wide lane (registered) |
| b_out | output | 2*LANE_W | Lane capture registers driven to the wide port |
| b_drive | output | 2 | Drive flag per wide lane |
| pick_low | input | 1 | Return lane select, 1 picks lane 0 (registered) |

## Verification
The bench sweeps all 64 combinations of the two load enables, the lane select and the three output enables, with data that differs in every cycle. This exposes a swapped lane, a swapped select polarity, an enable that acts one cycle early or late, and crossed output enables. A directed sequence packs two known words and also loads both lanes together, which separates correct packing from a lane loading out of turn. Changing the data inputs between edges shows whether either output path leaks through combinationally.

// File: rtl/bus_exchanger_pkg.sv
// Package: shared constants and the registered control bundle.
// Assumes exactly two wide-port lanes; internal controls are active-high.
package bus_exchanger_pkg;
    localparam int unsigned NUM_LANES = 2;

    typedef struct packed {
        logic                 pick_low;   // return register takes lane 0
        logic [NUM_LANES-1:0] lane_load;  // per-lane capture request
        logic                 a_drv;      // narrow port drives
        logic [NUM_LANES-1:0] b_drv;      // per-lane drive
    } ctrl_t;
endpackage

// File: rtl/bx_ctrl_stage.sv
// Module: bx_ctrl_stage
// Registers every control input once per clock and converts the active-low
// inputs to active-high internal flags. Reset leaves every port undriven,
// no lane loading and lane 1 selected.
module bx_ctrl_stage
    import bus_exchanger_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pick_low,
    input  logic [NUM_LANES-1:0] load_n,
    input  logic                 a_oe_n,
    input  logic [NUM_LANES-1:0] b_oe_n,
    output ctrl_t                ctrl_q
);

    // Control capture: one register stage for all controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.pick_low  <= pick_low;
            ctrl_q.lane_load <= ~load_n;
            ctrl_q.a_drv     <= ~a_oe_n;
            ctrl_q.b_drv     <= ~b_oe_n;
        end
    end

endmodule

// File: rtl/bx_lane_reg.sv
// Module: bx_lane_reg
// One wide-port lane capture register. It loads the narrow-port word when
// the registered load request is set and otherwise holds. Assumes the load
// request arrives already registered.
module bx_lane_reg #(
    parameter int unsigned LANE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] d,
    output logic [LANE_W-1:0] q
);

    // Lane storage: conditional capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/bx_return_reg.sv
// Module: bx_return_reg
// Return register for the narrow port. It loads on every edge from the wide
// lane chosen by the registered select: 1 picks lane 0, 0 picks lane 1.
module bx_return_reg #(
    parameter int unsigned LANE_W = 12,
    localparam int unsigned WIDE_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick_low,
    input  logic [WIDE_W-1:0] wide,
    output logic [LANE_W-1:0] q
);

    logic [LANE_W-1:0] chosen;

    // Lane choice: steer one half of the wide port.
    always_comb begin
        chosen = pick_low ? wide[LANE_W-1:0] : wide[WIDE_W-1:LANE_W];
    end

    // Return storage: unconditional load every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= chosen;
    end

    assert_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == ($past(pick_low) ? $past(wide[LANE_W-1:0])
                                                : $past(wide[WIDE_W-1:LANE_W]))));

endmodule

// File: rtl/bus_exchanger.sv
// Module: bus_exchanger (top)
// Exchanges data between a narrow port and a two-lane wide port. All
// controls pass through bx_ctrl_stage, so each acts one edge after it is
// sampled. Tri-state pins are replaced by data plus a drive flag.
module bus_exchanger
    import bus_exchanger_pkg::*;
#(
    parameter int unsigned LANE_W = 12,
    localparam int unsigned WIDE_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANE_W-1:0]    a_in,
    input  logic                 a_oe_n,
    output logic [LANE_W-1:0]    a_out,
    output logic                 a_drive,
    input  logic [WIDE_W-1:0]    b_in,
    input  logic [NUM_LANES-1:0] b_load_n,
    input  logic [NUM_LANES-1:0] b_oe_n,
    output logic [WIDE_W-1:0]    b_out,
    output logic [NUM_LANES-1:0] b_drive,
    input  logic                 pick_low
);

    ctrl_t ctrl_q;

    bx_ctrl_stage u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick_low (pick_low),
        .load_n   (b_load_n),
        .a_oe_n   (a_oe_n),
        .b_oe_n   (b_oe_n),
        .ctrl_q   (ctrl_q)
    );

    // One capture register per wide lane.
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        bx_lane_reg #(.LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ctrl_q.lane_load[k]),
            .d     (a_in),
            .q     (b_out[k*LANE_W +: LANE_W])
        );
    end

    bx_return_reg #(.LANE_W(LANE_W)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick_low (ctrl_q.pick_low),
        .wide     (b_in),
        .q        (a_out)
    );

    // Drive flags: straight from the registered enables.
    always_comb begin
        a_drive = ctrl_q.a_drv;
        b_drive = ctrl_q.b_drv;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!a_drive && (b_drive == '0) && (a_out == '0) && (b_out == '0)));

    assert_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((a_drive == !$past(a_oe_n)) && (b_drive == ~$past(b_oe_n))));

endmodule

// File: tb/bus_exchanger_bench.sv
module bus_exchanger_bench;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [LW-1:0] a_in;
    logic          a_oe_n;
    logic [LW-1:0] a_out;
    logic          a_drive;
    logic [2*LW-1:0] b_in;
    logic [1:0]    b_load_n;
    logic [1:0]    b_oe_n;
    logic [2*LW-1:0] b_out;
    logic [1:0]    b_drive;
    logic          pick_low;

    int compared = 0;
    int mismatched = 0;

    // model state
    logic [1:0]    m_load;   // registered load requests (active-high)
    logic          m_pick;
    logic          m_adrv;
    logic [1:0]    m_bdrv;
    logic [LW-1:0] m_lane [2];
    logic [LW-1:0] m_ret;

    always #4 clk = ~clk;

    bus_exchanger #(.LANE_W(LW)) u_bus_exchanger (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_oe_n(a_oe_n), .a_out(a_out),
        .a_drive(a_drive), .b_in(b_in), .b_load_n(b_load_n), .b_oe_n(b_oe_n),
        .b_out(b_out), .b_drive(b_drive), .pick_low(pick_low)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs now (at a negedge), clock once, update model, check at negedge.
    task automatic step(input logic [1:0] ld_n, input logic pk, input logic aoe,
                        input logic [1:0] boe, input logic [LW-1:0] a, input logic [2*LW-1:0] b);
        logic [1:0] prev_load;
        b_load_n = ld_n; pick_low = pk; a_oe_n = aoe; b_oe_n = boe; a_in = a; b_in = b;
        @(posedge clk);
        prev_load = m_load;
        if (!rst_n) begin
            m_load = 2'b00; m_pick = 1'b0; m_adrv = 1'b0; m_bdrv = 2'b00;
            m_lane[0] = '0; m_lane[1] = '0; m_ret = '0;
        end else begin
            if (m_load[0]) m_lane[0] = a;
            if (m_load[1]) m_lane[1] = a;
            m_ret  = m_pick ? b[LW-1:0] : b[2*LW-1:LW];
            m_load = ~ld_n; m_pick = pk; m_adrv = ~aoe; m_bdrv = ~boe;
        end
        @(negedge clk);
        if (rst_n) begin
            chk(prev_load[0] ? "R2 lane0 load" : "R3 lane0 hold", {20'd0, b_out[LW-1:0]}, {20'd0, m_lane[0]});
            chk(prev_load[1] ? "R2 lane1 load" : "R3 lane1 hold", {20'd0, b_out[2*LW-1:LW]}, {20'd0, m_lane[1]});
            chk("R6 return lane", {20'd0, a_out}, {20'd0, m_ret});
            chk("R8 drive flags", {29'd0, a_drive, b_drive}, {29'd0, m_adrv, m_bdrv});
        end
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        b_load_n = 2'b00; pick_low = 1'b1; a_oe_n = 1'b0; b_oe_n = 2'b00;
        a_in = 12'hFFF; b_in = 24'hFFFFFF;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(2'b00, 1'b1, 1'b0, 2'b00, 12'hFFF, 24'hFFFFFF);
        // R1: reset state
        chk("R1 a_drive", {31'd0, a_drive}, 32'd0);
        chk("R1 b_drive", {30'd0, b_drive}, 32'd0);
        chk("R1 a_out", {20'd0, a_out}, 32'd0);
        chk("R1 b_out", {8'd0, b_out}, 32'd0);
        rst_n = 1'b1;
        step(2'b11, 1'b0, 1'b1, 2'b11, 12'h000, 24'h000000);

        // Sweep every control combination with changing data (R2 R3 R6 R8).
        for (int pass = 0; pass < 3; pass++) begin
            for (int c = 0; c < 64; c++) begin
                logic [5:0] cv;
                logic [LW-1:0] av;
                logic [2*LW-1:0] bv;
                cv = c[5:0] ^ pass[5:0];
                av = LW'((c * 37 + pass * 611 + 5) & 12'hFFF);
                bv = {LW'((c * 91 + pass * 7) & 12'hFFF), LW'((c * 53 + pass * 1301 + 7) & 12'hFFF)};
                step(cv[1:0], cv[2], cv[3], cv[5:4], av, bv);
            end
        end

        // R4: pack two sequential words.
        step(2'b10, 1'b0, 1'b0, 2'b00, 12'h000, 24'h0);
        step(2'b01, 1'b0, 1'b0, 2'b00, 12'hABC, 24'h0);
        step(2'b11, 1'b0, 1'b0, 2'b00, 12'h123, 24'h0);
        chk("R4 packed word", {8'd0, b_out}, {8'd0, 24'h123ABC});

        // R5: both lanes load together.
        step(2'b00, 1'b0, 1'b0, 2'b00, 12'h777, 24'h0);
        step(2'b11, 1'b0, 1'b0, 2'b00, 12'h5A5, 24'h0);
        chk("R5 both lanes", {8'd0, b_out}, {8'd0, 24'h5A55A5});

        // R7: input changes between edges do not reach outputs.
        step(2'b00, 1'b1, 1'b0, 2'b00, 12'h0F0, 24'h333444);
        chk("R7 setup a_out", {20'd0, a_out}, {20'd0, m_ret});
        a_in = 12'hEEE; b_in = 24'hCCCDDD;
        #1;
        chk("R7 a_out stable", {20'd0, a_out}, {20'd0, m_ret});
        chk("R7 b_out stable", {8'd0, b_out}, {8'd0, m_lane[1], m_lane[0]});
        #2;
        chk("R7 a_out stable late", {20'd0, a_out}, {20'd0, m_ret});

        // R8: each output enable alone.
        step(2'b11, 1'b0, 1'b0, 2'b11, 12'h0, 24'h0);
        chk("R8 only a drives", {29'd0, a_drive, b_drive}, 32'b100);
        step(2'b11, 1'b0, 1'b1, 2'b10, 12'h0, 24'h0);
        chk("R8 only lane0 drives", {29'd0, a_drive, b_drive}, 32'b001);
        step(2'b11, 1'b0, 1'b1, 2'b01, 12'h0, 24'h0);
        chk("R8 only lane1 drives", {29'd0, a_drive, b_drive}, 32'b010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule